// File: doc/BRIEF.md
# Directory Coherence Home Controller

This block sits on the memory side of a small multiprocessor. It owns a fixed set of memory blocks and keeps one directory entry for each of them. An entry is in one of three states: Uncached, Shared or Modified. It also holds a vector with one bit per cache. In Shared the vector lists every cache that holds a clean copy. In Modified it holds a single bit that names the owner. Caches reach the controller over point-to-point channels, with no shared bus. A cache that misses sends a read or an ownership request. The controller answers it directly, or first sends targeted messages to the caches named in the entry.

The block has three outgoing message types. An invalidate tells a sharer to drop its copy. A fetch tells the owner to return its data and keep a clean shared copy. A fetch-invalidate tells the owner to return its data and drop its copy. One message covers all targets, because its mask names every cache that must act. The controller counts the acknowledgements it still expects and ignores acks from caches it did not target. It sends the grant only after the count reaches zero. Data returned by an owner is written to the home memory and passed on to the requester. The controller serves one transaction at a time. While it waits for acknowledgements, the request channel is held off. A combinational probe port shows any directory entry.

Top module: `dir_home_ctrl`

## Requirements
- R1: After reset every block reads back through the probe as Uncached with an empty vector, every memory word is zero, req_ready is 1, and rsp_valid and fwd_valid are 0.
- R2: A read (req_own=0) to an Uncached or Shared block sends no forward message. One cycle after acceptance, rsp_valid pulses with rsp_excl=0 and the memory data. The requester's bit is set and the entry becomes Shared.
- R3: A read to a block Modified in another cache sends fwd_kind=1 (fetch, owner keeps a clean copy) to the owner only. The data the owner returns is written to memory and sent to the requester with rsp_excl=0. The entry becomes Shared with the owner and the requester as sharers.
- R4: An ownership request (req_own=1) to a Shared block with other sharers sends one message with fwd_kind=0 (invalidate). Its mask holds exactly the other sharers. The grant comes only after all of them acknowledge. The entry then becomes Modified with the requester alone, and no other cache still holds a copy when the grant arrives.
- R5: An ownership request to a block that no other cache holds sends no forward message. This covers an Uncached block and a Shared block whose only sharer is the requester. One cycle after acceptance, rsp_valid pulses with rsp_excl=1 and the memory data.
- R6: An ownership request to a block Modified in another cache sends fwd_kind=2 (fetch and invalidate) to the owner. The returned data is written to memory and sent to the requester with rsp_excl=1. The old owner is removed from the entry.
- R7: The response appears in the cycle after the last outstanding acknowledgement is presented. An ack_valid bit from a cache outside the outstanding set has no effect.
- R8: While forward messages are outstanding, req_ready stays 0. It returns to 1 in the cycle the response is presented.
- R9: Response data always equals the value most recently written by any cache that held the block exclusively, or zero if no cache has written it.
- R10: probe_addr selects an entry combinationally. probe_state shows its state (0 Uncached, 1 Shared, 2 Modified) and probe_vec shows its vector.
- R11: Every entry keeps three rules. An Uncached entry has an empty vector, a Shared entry has at least one bit set, and a Modified entry has exactly one bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_src | input | IDW | Requesting cache index |
| req_own | input | 1 | 1 = ownership (write miss or upgrade), 0 = read |
| req_addr | input | AW | Block index |
| fwd_valid | output | 1 | Forward message pulse |
| fwd_kind | output | 2 | 0 invalidate, 1 fetch, 2 fetch and invalidate |
| fwd_mask | output | NCACHE | Target caches |
| fwd_addr | output | AW | Block concerned |
| ack_valid | input | NCACHE | Per-cache acknowledgement pulse |
| ack_data | input | NCACHE*DW | Per-cache returned data |
| rsp_valid | output | 1 | Response pulse |
| rsp_dst | output | IDW | Destination cache |
| rsp_excl | output | 1 | 1 exclusive grant, 0 shared copy |
| rsp_addr | output | AW | Block concerned |
| rsp_data | output | DW | Block data |
| probe_addr | input | AW | Directory entry to observe |
| probe_state | output | 2 | State of the probed entry |
| probe_vec | output | NCACHE | Sharer or owner vector of the probed entry |

## Verification
A wrong sharer vector shows up at the ports in one of three ways. An invalidate mask can miss a cache that holds a copy, or name one that holds none. A grant can reach a requester while a stale copy survives elsewhere. The next read can return old data. The bench keeps stub caches whose holdings change only through the messages they actually receive, and compares the probe against those holdings right after each response. A fault in the acknowledgement count shows up within a single transaction as a grant that comes early or late. Stray acks are injected to expose a count that does not mask them.

// File: rtl/dir_home_ctrl.sv
module dir_home_ctrl #(
  parameter int NCACHE = 4,
  parameter int NBLK   = 16,
  parameter int DW     = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [$clog2(NCACHE)-1:0] req_src,
  input  logic                 req_own,
  input  logic [$clog2(NBLK)-1:0]   req_addr,
  output logic                 fwd_valid,
  output logic [1:0]           fwd_kind,
  output logic [NCACHE-1:0]    fwd_mask,
  output logic [$clog2(NBLK)-1:0]   fwd_addr,
  input  logic [NCACHE-1:0]    ack_valid,
  input  logic [NCACHE*DW-1:0] ack_data,
  output logic                 rsp_valid,
  output logic [$clog2(NCACHE)-1:0] rsp_dst,
  output logic                 rsp_excl,
  output logic [$clog2(NBLK)-1:0]   rsp_addr,
  output logic [DW-1:0]        rsp_data,
  input  logic [$clog2(NBLK)-1:0]   probe_addr,
  output logic [1:0]           probe_state,
  output logic [NCACHE-1:0]    probe_vec
);
  localparam int IDW = $clog2(NCACHE);
  localparam int AW  = $clog2(NBLK);
  localparam int CW  = $clog2(NCACHE + 1);
  localparam logic [1:0] ST_U = 2'd0, ST_S = 2'd1, ST_M = 2'd2;
  localparam logic [1:0] FW_INV = 2'd0, FW_FETCH = 2'd1, FW_FETCH_INV = 2'd2;
  localparam logic [NCACHE-1:0] ONE = {{(NCACHE-1){1'b0}}, 1'b1};

  logic [1:0]        st_q  [NBLK];
  logic [NCACHE-1:0] vec_q [NBLK];
  logic [DW-1:0]     mem_q [NBLK];

  logic              busy_q;
  logic [IDW-1:0]    src_q;
  logic              own_q;
  logic              fetch_q;
  logic [AW-1:0]     addr_q;
  logic [NCACHE-1:0] pend_q;
  logic [CW-1:0]     cnt_q;

  wire               accept   = req_valid && !busy_q;
  wire [1:0]         cur_st   = st_q[req_addr];
  wire [NCACHE-1:0]  cur_vec  = vec_q[req_addr];
  wire [NCACHE-1:0]  src_bit  = ONE << req_src;
  wire [NCACHE-1:0]  others   = cur_vec & ~src_bit;
  wire               need_fwd = (others != '0) && ((cur_st == ST_M) || (req_own && cur_st == ST_S));
  wire [NCACHE-1:0]  srcq_bit = ONE << src_q;
  wire [NCACHE-1:0]  ack_hit  = ack_valid & pend_q;
  wire [CW-1:0]      cnt_nxt  = cnt_q - CW'($countones(ack_hit));

  logic [DW-1:0] ack_sel;
  always_comb begin
    ack_sel = '0;
    for (int i = 0; i < NCACHE; i++)
      if (ack_hit[i]) ack_sel = ack_data[i*DW +: DW];
  end

  assign req_ready   = !busy_q;
  assign probe_state = st_q[probe_addr];
  assign probe_vec   = vec_q[probe_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < NBLK; b++) begin
        st_q[b]  <= ST_U;
        vec_q[b] <= '0;
        mem_q[b] <= '0;
      end
      busy_q <= 1'b0; src_q <= '0; own_q <= 1'b0; fetch_q <= 1'b0;
      addr_q <= '0; pend_q <= '0; cnt_q <= '0;
      fwd_valid <= 1'b0; fwd_kind <= FW_INV; fwd_mask <= '0; fwd_addr <= '0;
      rsp_valid <= 1'b0; rsp_dst <= '0; rsp_excl <= 1'b0; rsp_addr <= '0; rsp_data <= '0;
    end else begin
      rsp_valid <= 1'b0;
      fwd_valid <= 1'b0;
      if (accept) begin
        addr_q <= req_addr;
        src_q  <= req_src;
        own_q  <= req_own;
        if (need_fwd) begin
          busy_q    <= 1'b1;
          pend_q    <= others;
          cnt_q     <= CW'($countones(others));
          fetch_q   <= (cur_st == ST_M);
          fwd_valid <= 1'b1;
          fwd_mask  <= others;
          fwd_addr  <= req_addr;
          fwd_kind  <= (cur_st != ST_M) ? FW_INV : (req_own ? FW_FETCH_INV : FW_FETCH);
        end else begin
          rsp_valid <= 1'b1;
          rsp_dst   <= req_src;
          rsp_addr  <= req_addr;
          rsp_data  <= mem_q[req_addr];
          if (req_own || cur_st == ST_M) begin
            rsp_excl        <= 1'b1;
            st_q[req_addr]  <= ST_M;
            vec_q[req_addr] <= src_bit;
          end else begin
            rsp_excl        <= 1'b0;
            st_q[req_addr]  <= ST_S;
            vec_q[req_addr] <= cur_vec | src_bit;
          end
        end
      end else if (busy_q) begin
        pend_q <= pend_q & ~ack_valid;
        cnt_q  <= cnt_nxt;
        if (cnt_nxt == '0) begin
          busy_q    <= 1'b0;
          rsp_valid <= 1'b1;
          rsp_dst   <= src_q;
          rsp_addr  <= addr_q;
          rsp_excl  <= own_q;
          rsp_data  <= fetch_q ? ack_sel : mem_q[addr_q];
          if (fetch_q) mem_q[addr_q] <= ack_sel;
          st_q[addr_q]  <= own_q ? ST_M : ST_S;
          vec_q[addr_q] <= own_q ? srcq_bit : (vec_q[addr_q] | srcq_bit);
        end
      end
    end
  end

  assert_count_tracks_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q == CW'($countones(pend_q))));

  assert_wait_never_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (pend_q != '0));

  assert_ready_low_while_forwarding_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid |-> (!req_ready && !rsp_valid));

  assert_fwd_skips_requester_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid |-> ((fwd_mask != '0) && !fwd_mask[src_q]));

  assert_grant_sole_holder_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_excl) |-> ((vec_q[rsp_addr] == (ONE << rsp_dst)) && (st_q[rsp_addr] == ST_M)));

  assert_shared_rsp_listed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_excl) |-> (vec_q[rsp_addr][rsp_dst] && (st_q[rsp_addr] == ST_S)));

  for (genvar b = 0; b < NBLK; b++) begin : g_inv
    assert_entry_shape_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ((st_q[b] == ST_U) && (vec_q[b] == '0)) ||
      ((st_q[b] == ST_S) && (vec_q[b] != '0)) ||
      ((st_q[b] == ST_M) && $onehot(vec_q[b])));
  end
endmodule

// File: tb/dir_home_ctrl_tb.sv
module dir_home_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 4;
  localparam int NB = 16;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [1:0] req_src = '0;
  logic req_own = 1'b0;
  logic [3:0] req_addr = '0;
  logic fwd_valid;
  logic [1:0] fwd_kind;
  logic [NC-1:0] fwd_mask;
  logic [3:0] fwd_addr;
  logic [NC-1:0] ack_valid = '0;
  logic [NC*DW-1:0] ack_data = '0;
  logic rsp_valid;
  logic [1:0] rsp_dst;
  logic rsp_excl;
  logic [3:0] rsp_addr;
  logic [DW-1:0] rsp_data;
  logic [3:0] probe_addr = '0;
  logic [1:0] probe_state;
  logic [NC-1:0] probe_vec;

  int checks = 0;
  int fails = 0;
  int hold [NC][NB];
  logic [DW-1:0] val [NC][NB];
  logic [DW-1:0] gold [NB];

  always #(CLK_PERIOD/2) clk = ~clk;

  dir_home_ctrl #(.NCACHE(NC), .NBLK(NB), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_src(req_src), .req_own(req_own), .req_addr(req_addr),
    .fwd_valid(fwd_valid), .fwd_kind(fwd_kind), .fwd_mask(fwd_mask), .fwd_addr(fwd_addr),
    .ack_valid(ack_valid), .ack_data(ack_data),
    .rsp_valid(rsp_valid), .rsp_dst(rsp_dst), .rsp_excl(rsp_excl), .rsp_addr(rsp_addr), .rsp_data(rsp_data),
    .probe_addr(probe_addr), .probe_state(probe_state), .probe_vec(probe_vec));

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  function automatic logic [NC-1:0] model_vec(input int a);
    logic [NC-1:0] v = '0;
    for (int c = 0; c < NC; c++) if (hold[c][a] != 0) v[c] = 1'b1;
    return v;
  endfunction

  function automatic int model_state(input int a);
    int st = 0;
    for (int c = 0; c < NC; c++) begin
      if (hold[c][a] == 2) st = 2;
      else if (hold[c][a] == 1 && st == 0) st = 1;
    end
    return st;
  endfunction

  task automatic check_probe(input int a, input string rq);
    probe_addr = 4'(a);
    #1;
    chk(int'(probe_state) == model_state(a), rq, "probe state", int'(probe_state), model_state(a));
    chk(probe_vec == model_vec(a), rq, "probe vector", int'(probe_vec), int'(model_vec(a)));
  endtask

  task automatic do_req(input int s, input bit own, input int a);
    logic [NC-1:0] vec_b = model_vec(a);
    logic [NC-1:0] others = vec_b & ~(NC'(1) << s);
    int owner = -1;
    bit exp_fwd;
    int exp_kind;
    logic [DW-1:0] exp_data = gold[a];
    string rq;
    int cyc = 1;
    int last = 0;
    int rcyc = 0;
    bit got_fwd = 0;
    bit done = 0;
    int fk = 0;
    bit pend [NC];
    int dly [NC];
    for (int c = 0; c < NC; c++) begin
      pend[c] = 0; dly[c] = 0;
      if (hold[c][a] == 2) owner = c;
    end
    exp_fwd  = (owner >= 0) || (own && others != '0);
    exp_kind = (owner >= 0) ? (own ? 2 : 1) : 0;
    if (own) rq = (owner >= 0) ? "R6" : ((others != '0) ? "R4" : "R5");
    else     rq = (owner >= 0) ? "R3" : "R2";

    @(negedge clk);
    req_valid = 1'b1; req_src = 2'(s); req_own = own; req_addr = 4'(a);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!done) begin
      if (rsp_valid) begin
        done = 1; rcyc = cyc;
      end else begin
        chk(req_ready == 1'b0, "R8", "ready while waiting", int'(req_ready), 0);
        if (fwd_valid) begin
          got_fwd = 1; fk = int'(fwd_kind);
          chk(fwd_mask == others, rq, "forward mask", int'(fwd_mask), int'(others));
          chk(int'(fwd_kind) == exp_kind, rq, "forward kind", int'(fwd_kind), exp_kind);
          chk(int'(fwd_addr) == a, rq, "forward addr", int'(fwd_addr), a);
          for (int c = 0; c < NC; c++)
            if (fwd_mask[c]) begin pend[c] = 1; dly[c] = $urandom_range(0, 3); end
        end
        ack_valid = '0;
        for (int c = 0; c < NC; c++) begin
          if (pend[c]) begin
            if (dly[c] == 0) begin
              ack_valid[c] = 1'b1;
              ack_data[c*DW +: DW] = val[c][a];
              hold[c][a] = (fk == 1) ? 1 : 0;
              pend[c] = 0;
              last = cyc;
            end else dly[c]--;
          end
        end
        begin
          bit still = 0;
          for (int c = 0; c < NC; c++) if (pend[c]) still = 1;
          if (still && ($urandom_range(0, 2) == 0)) begin
            for (int c = 0; c < NC; c++)
              if (!others[c] && !ack_valid[c]) begin
                ack_valid[c] = 1'b1;
                ack_data[c*DW +: DW] = 8'hEE;
                break;
              end
          end
        end
        if (cyc > 40) begin
          chk(1'b0, rq, "response timeout", cyc, 0);
          done = 1;
        end
        cyc++;
        @(negedge clk);
      end
    end
    ack_valid = '0;
    if (rcyc == 0) return;
    chk(got_fwd == exp_fwd, rq, "forward issued", int'(got_fwd), int'(exp_fwd));
    if (exp_fwd) chk(rcyc == last + 1, "R7", "grant cycle after last ack", rcyc, last + 1);
    else         chk(rcyc == 1, rq, "immediate response cycle", rcyc, 1);
    chk(int'(rsp_dst) == s, rq, "response dest", int'(rsp_dst), s);
    chk(rsp_excl == own, rq, "response kind", int'(rsp_excl), int'(own));
    chk(int'(rsp_addr) == a, rq, "response addr", int'(rsp_addr), a);
    chk(rsp_data == exp_data, "R9", "response data", int'(rsp_data), int'(exp_data));
    hold[s][a] = own ? 2 : 1;
    val[s][a] = rsp_data;
    if (own) begin
      logic [DW-1:0] nv = DW'($urandom);
      val[s][a] = nv;
      gold[a] = nv;
      for (int c = 0; c < NC; c++)
        if (c != s) chk(hold[c][a] == 0, "R4", "surviving copy at grant", hold[c][a], 0);
    end
    check_probe(a, "R10");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual expired expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int c = 0; c < NC; c++)
      for (int b = 0; b < NB; b++) begin hold[c][b] = 0; val[c][b] = '0; end
    for (int b = 0; b < NB; b++) gold[b] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1", "ready after reset", int'(req_ready), 1);
    chk(rsp_valid == 1'b0, "R1", "rsp idle after reset", int'(rsp_valid), 0);
    chk(fwd_valid == 1'b0, "R1", "fwd idle after reset", int'(fwd_valid), 0);
    for (int b = 0; b < NB; b++) begin
      probe_addr = 4'(b);
      #1;
      chk(probe_state == 2'd0 && probe_vec == '0, "R1", "entry uncached after reset",
          int'(probe_state), 0);
    end

    do_req(0, 0, 1);
    do_req(1, 0, 1);
    do_req(2, 0, 1);
    do_req(3, 1, 1);
    do_req(0, 0, 1);
    do_req(1, 1, 1);
    do_req(2, 1, 1);
    do_req(0, 1, 2);
    do_req(1, 0, 3);
    do_req(1, 1, 3);
    do_req(2, 0, 3);
    do_req(0, 0, 3);
    do_req(3, 1, 3);

    for (int n = 0; n < 400; n++) begin
      int s = $urandom_range(0, NC-1);
      int a = $urandom_range(0, 5);
      bit own = 1'($urandom_range(0, 1));
      if (hold[s][a] == 2) continue;
      if (hold[s][a] == 1) own = 1;
      do_req(s, own, a);
    end

    for (int b = 0; b < NB; b++) check_probe(b, "R11");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule